// File: doc/BRIEF.md
# Serial Channel Start/Stop Sequencer

This block is the command state machine of one serial-bus master channel. A host issues command writes that carry three bits: begin, halt and end-of-sequence. A byte engine beside the block moves the actual bits on the wire and reports three events: an acknowledge slot has finished, a frame has finished, and a STOP condition has gone out. The sequencer turns these inputs into one-cycle requests for the engine: issue START, issue STOP, abandon at once. It also pulses a byte-count update and keeps two sticky flags, sequence-done and loop-done.

There are three operating modes. Single run executes the stored transfer once. Refresh loop repeats it, and between frames the channel sits in a loop gap until a periodic tick starts the next frame. Trigger loop does the same with an external trigger. The two loop modes treat the end-of-sequence command with opposite timing. In refresh mode it drops the channel at once from the gap and lets a running frame finish. In trigger mode it lets the frame finish when issued from the gap and drops the channel at once while a frame runs.

Top module: `chan_stop_seq`

## Requirements
- R1: After reset, state_o is 3'b000 (inactive), both flags are 0 and no request or count pulse is asserted.
- R2: In the inactive state a write with begin=1 produces a one-cycle start_req_o in the cycle after the write, and state_o becomes 3'b001 (frame running). A write with begin=0 produces nothing.
- R3: While the channel is not inactive, the begin bit of a write never produces start_req_o.
- R4: A write with halt=1 while a frame runs in single or refresh mode waits for ack_done_i. In the cycle after that event, stop_req_o and cnt_upd_o pulse together, seq_done_o sets, and state_o becomes 3'b101 (stopping). frame_loop_done_o also sets in the loop modes.
- R5: In refresh mode, in the loop gap (state_o 3'b011), a write with halt=1 or end-of-sequence=1 produces abort_o in the next cycle, returns state_o to 3'b000, and sets both flags.
- R6: In refresh mode, end-of-sequence=1 with halt=0 during a running frame ignores ack_done_i. On frame_done_i it produces stop_req_o without cnt_upd_o, sets both flags and enters 3'b101.
- R7: In trigger mode, in the loop gap, end-of-sequence alone is held until the end of the next frame and then stops it. Halt=1 in the gap stops after the next ack_done_i with a count update. Both paths set both flags.
- R8: In trigger mode, a halt=1 or end-of-sequence=1 write during a running frame produces abort_o in the next cycle, returns state_o to 3'b000, and sets both flags.
- R9: In either loop mode, a write with halt=0 and end-of-sequence=0 changes neither state_o nor any output.
- R10: seq_done_o and frame_loop_done_o stay set until flag_clr_i. A set event in the same cycle as flag_clr_i wins.
- R11: When halt and end-of-sequence are written together, halt takes effect: the stop follows ack_done_i with a count update.
- R12: Once a stop is pending or state_o is 3'b101, further writes are ignored. The channel leaves 3'b101 for 3'b000 only on stop_sent_i.
- R13: In a loop mode, frame_done_i with nothing pending enters the loop gap, and next_go_i there restarts a frame with start_req_o. In single mode, frame_done_i returns the channel to 3'b000 and sets seq_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host command write strobe |
| cmd_begin_i | input | 1 | Begin bit of the write |
| cmd_halt_i | input | 1 | Halt bit of the write |
| cmd_endseq_i | input | 1 | End-of-sequence bit of the write |
| loop_en_i | input | 1 | Refresh-loop mode when trigger mode is off |
| trig_en_i | input | 1 | Trigger-loop mode (overrides loop_en_i) |
| ack_done_i | input | 1 | Engine: acknowledge slot finished |
| frame_done_i | input | 1 | Engine: frame finished |
| stop_sent_i | input | 1 | Engine: STOP condition issued |
| next_go_i | input | 1 | Refresh tick or trigger event that starts the next frame |
| flag_clr_i | input | 1 | Clear both sticky flags |
| start_req_o | output | 1 | Request START and a frame |
| stop_req_o | output | 1 | Request STOP |
| abort_o | output | 1 | Drop the channel at once |
| cnt_upd_o | output | 1 | Update the byte count |
| state_o | output | 3 | Channel state: 000 inactive, 001 running, 011 loop gap, 101 stopping |
| seq_done_o | output | 1 | Sticky sequence-done flag |
| frame_loop_done_o | output | 1 | Sticky loop-done flag |

## Verification
The hardest cases to reach are the mode-dependent end-of-sequence paths. They call for a loop mode, a completed first frame so the channel sits in the gap, and then either a gap command or a next_go_i restart followed by a mid-frame command. Each scenario task walks this path through start, frame_done_i and next_go_i before it issues the command. It then sends the opposite engine event first, for example ack_done_i before frame_done_i, to show that a pending end-of-sequence stop waits for the right event. The halt-over-end-of-sequence priority and the ignoring of later writes are shown the same way: a single ack_done_i either produces a counted stop or nothing.

// File: rtl/chan_stop_seq_pkg.sv
package chan_stop_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_RUN  = 3'b001,
    ST_GAP  = 3'b011,
    ST_STOP = 3'b101
  } chan_st_e;

  typedef enum logic [1:0] {
    MD_SINGLE  = 2'd0,
    MD_REFRESH = 2'd1,
    MD_TRIG    = 2'd2
  } mode_e;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_SD   = 0;
  localparam int unsigned FLAG_FLD  = 1;
endpackage

// File: rtl/chan_stop_seq_mode.sv
module chan_stop_seq_mode
  import chan_stop_seq_pkg::*;
(
  input  logic  loop_en_i,
  input  logic  trig_en_i,
  output mode_e mode_o
);
  always_comb begin
    if (trig_en_i)      mode_o = MD_TRIG;
    else if (loop_en_i) mode_o = MD_REFRESH;
    else                mode_o = MD_SINGLE;
  end
endmodule

// File: rtl/chan_stop_seq_cmd.sv
module chan_stop_seq_cmd
  import chan_stop_seq_pkg::*;
(
  input  chan_st_e st_i,
  input  mode_e    mode_i,
  input  logic     busy_i,
  input  logic     wr_i,
  input  logic     begin_i,
  input  logic     halt_i,
  input  logic     endseq_i,
  output logic     act_start_o,
  output logic     act_abort_o,
  output logic     act_pend_ack_o,
  output logic     act_pend_frm_o
);
  logic acc;
  assign acc = wr_i && !busy_i;

  always_comb begin
    act_start_o    = 1'b0;
    act_abort_o    = 1'b0;
    act_pend_ack_o = 1'b0;
    act_pend_frm_o = 1'b0;
    if (acc) begin
      unique case (st_i)
        ST_IDLE: act_start_o = begin_i;
        ST_RUN: begin
          if (mode_i == MD_TRIG) act_abort_o = halt_i || endseq_i;
          else if (halt_i)       act_pend_ack_o = 1'b1;
          else if (mode_i == MD_REFRESH) act_pend_frm_o = endseq_i;
        end
        ST_GAP: begin
          if (mode_i == MD_REFRESH) act_abort_o = halt_i || endseq_i;
          else if (mode_i == MD_TRIG) begin
            // halt outranks end-of-sequence
            if (halt_i) act_pend_ack_o = 1'b1;
            else        act_pend_frm_o = endseq_i;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chan_stop_seq_flags.sv
module chan_stop_seq_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i)    q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_stop_seq.sv
module chan_stop_seq
  import chan_stop_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic       cmd_begin_i,
  input  logic       cmd_halt_i,
  input  logic       cmd_endseq_i,
  input  logic       loop_en_i,
  input  logic       trig_en_i,
  input  logic       ack_done_i,
  input  logic       frame_done_i,
  input  logic       stop_sent_i,
  input  logic       next_go_i,
  input  logic       flag_clr_i,
  output logic       start_req_o,
  output logic       stop_req_o,
  output logic       abort_o,
  output logic       cnt_upd_o,
  output logic [2:0] state_o,
  output logic       seq_done_o,
  output logic       frame_loop_done_o
);
  mode_e    mode;
  chan_st_e st_q, st_d;
  logic     pa_q, pa_d, pf_q, pf_d;
  logic     busy, in_loop;
  logic     a_start, a_abort, a_pack, a_pfrm;
  logic     e_start, e_stop, e_abort, e_cnt;
  logic [NUM_FLAGS-1:0] fl_set, fl_q;

  assign busy    = pa_q || pf_q || (st_q == ST_STOP);
  assign in_loop = (mode != MD_SINGLE);

  chan_stop_seq_mode u_mode (
    .loop_en_i (loop_en_i),
    .trig_en_i (trig_en_i),
    .mode_o    (mode)
  );

  chan_stop_seq_cmd u_cmd (
    .st_i           (st_q),
    .mode_i         (mode),
    .busy_i         (busy),
    .wr_i           (cmd_wr_i),
    .begin_i        (cmd_begin_i),
    .halt_i         (cmd_halt_i),
    .endseq_i       (cmd_endseq_i),
    .act_start_o    (a_start),
    .act_abort_o    (a_abort),
    .act_pend_ack_o (a_pack),
    .act_pend_frm_o (a_pfrm)
  );

  always_comb begin
    st_d    = st_q;
    pa_d    = pa_q;
    pf_d    = pf_q;
    e_start = 1'b0;
    e_stop  = 1'b0;
    e_abort = 1'b0;
    e_cnt   = 1'b0;
    fl_set  = '0;
    if (a_abort) begin
      st_d    = ST_IDLE;
      pa_d    = 1'b0;
      pf_d    = 1'b0;
      e_abort = 1'b1;
      fl_set  = '1;
    end else begin
      if (a_pack) pa_d = 1'b1;
      if (a_pfrm) pf_d = 1'b1;
      if (pa_q && ack_done_i && (st_q == ST_RUN || st_q == ST_GAP)) begin
        st_d   = ST_STOP;
        pa_d   = 1'b0;
        pf_d   = 1'b0;
        e_stop = 1'b1;
        e_cnt  = 1'b1;
        fl_set[FLAG_SD]  = 1'b1;
        fl_set[FLAG_FLD] = in_loop;
      end else begin
        unique case (st_q)
          ST_IDLE: if (a_start) begin
            st_d    = ST_RUN;
            e_start = 1'b1;
          end
          ST_RUN: if (frame_done_i && !pa_q) begin
            if (pf_q) begin
              st_d   = ST_STOP;
              pf_d   = 1'b0;
              e_stop = 1'b1;
              fl_set = '1;
            end else if (in_loop) begin
              st_d = ST_GAP;
            end else begin
              st_d = ST_IDLE;
              fl_set[FLAG_SD] = 1'b1;
            end
          end
          ST_GAP: if (next_go_i) begin
            st_d    = ST_RUN;
            e_start = 1'b1;
          end
          ST_STOP: if (stop_sent_i) begin
            st_d = ST_IDLE;
            pa_d = 1'b0;
            pf_d = 1'b0;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pa_q        <= 1'b0;
      pf_q        <= 1'b0;
      start_req_o <= 1'b0;
      stop_req_o  <= 1'b0;
      abort_o     <= 1'b0;
      cnt_upd_o   <= 1'b0;
    end else begin
      st_q        <= st_d;
      pa_q        <= pa_d;
      pf_q        <= pf_d;
      start_req_o <= e_start;
      stop_req_o  <= e_stop;
      abort_o     <= e_abort;
      cnt_upd_o   <= e_cnt;
    end
  end

  chan_stop_seq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fl_set),
    .clr_i  (flag_clr_i),
    .q_o    (fl_q)
  );

  assign state_o           = st_q;
  assign seq_done_o        = fl_q[FLAG_SD];
  assign frame_loop_done_o = fl_q[FLAG_FLD];
endmodule

// File: rtl/chan_stop_seq_chk.sv
module chan_stop_seq_chk
  import chan_stop_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_wr_i,
  input logic       cmd_begin_i,
  input logic       flag_clr_i,
  input logic       start_req_o,
  input logic       stop_req_o,
  input logic       abort_o,
  input logic       cnt_upd_o,
  input logic [2:0] state_o,
  input logic       seq_done_o,
  input logic       frame_loop_done_o
);
  AST_START_FROM_IDLE_OR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> ($past(state_o) == ST_IDLE || $past(state_o) == ST_GAP)); // R3
  AST_IDLE_NO_BEGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && cmd_wr_i && !cmd_begin_i) |=> !start_req_o); // R2
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_req_o, stop_req_o, abort_o})); // R12
  AST_CNT_WITH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_upd_o |-> (stop_req_o && state_o == ST_STOP && seq_done_o)); // R4
  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (state_o == ST_IDLE && seq_done_o && frame_loop_done_o)); // R5
  AST_SD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(seq_done_o) |-> $past(flag_clr_i)); // R10
  AST_FLD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_loop_done_o) |-> $past(flag_clr_i)); // R10
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |-> state_o == ST_STOP); // R12
endmodule

bind chan_stop_seq chan_stop_seq_chk u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .cmd_wr_i          (cmd_wr_i),
  .cmd_begin_i       (cmd_begin_i),
  .flag_clr_i        (flag_clr_i),
  .start_req_o       (start_req_o),
  .stop_req_o        (stop_req_o),
  .abort_o           (abort_o),
  .cnt_upd_o         (cnt_upd_o),
  .state_o           (state_o),
  .seq_done_o        (seq_done_o),
  .frame_loop_done_o (frame_loop_done_o)
);

// File: tb/chan_stop_seq_test.sv
`timescale 1ns/1ps
module chan_stop_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, b = 0, h = 0, es = 0, loop_en = 0, trig_en = 0;
  logic ack = 0, frm = 0, ssent = 0, go = 0, clr = 0;
  logic start_req, stop_req, abort_w, cnt_upd, sd, fld;
  logic [2:0] st;
  int n_chk = 0, n_fail = 0;

  localparam logic [2:0] S_IDLE = 3'b000, S_RUN = 3'b001, S_GAP = 3'b011, S_STOP = 3'b101;

  always #5 clk = ~clk;

  chan_stop_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(wr), .cmd_begin_i(b), .cmd_halt_i(h),
    .cmd_endseq_i(es), .loop_en_i(loop_en), .trig_en_i(trig_en), .ack_done_i(ack),
    .frame_done_i(frm), .stop_sent_i(ssent), .next_go_i(go), .flag_clr_i(clr),
    .start_req_o(start_req), .stop_req_o(stop_req), .abort_o(abort_w), .cnt_upd_o(cnt_upd),
    .state_o(st), .seq_done_o(sd), .frame_loop_done_o(fld)
  );

  // expected: state, {start,stop,abort,cnt}, sd, fld
  task automatic chk(input string tag, input logic [2:0] e_st, input logic [3:0] e_pl,
                     input logic e_sd, input logic e_fld);
    logic [8:0] act, exp;
    act = {st, start_req, stop_req, abort_w, cnt_upd, sd, fld};
    exp = {e_st, e_pl, e_sd, e_fld};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write(input logic vb, input logic vh, input logic ve);
    @(negedge clk); wr = 1; b = vb; h = vh; es = ve;
    @(negedge clk); wr = 0; b = 0; h = 0; es = 0;
  endtask

  task automatic ev(input logic va, input logic vf, input logic vs, input logic vg);
    @(negedge clk); ack = va; frm = vf; ssent = vs; go = vg;
    @(negedge clk); ack = 0; frm = 0; ssent = 0; go = 0;
  endtask

  task automatic flags_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", S_IDLE, 4'b0000, 0, 0);
  endtask

  task automatic t_single();
    loop_en = 0; trig_en = 0;
    write(0, 0, 0);   chk("R2 begin=0 idle", S_IDLE, 4'b0000, 0, 0);
    write(1, 0, 0);   chk("R2 begin=1 idle", S_RUN, 4'b1000, 0, 0);
    write(1, 0, 0);   chk("R3 begin while running", S_RUN, 4'b0000, 0, 0);
    write(0, 1, 0);   chk("R4 halt waits for ack", S_RUN, 4'b0000, 0, 0);
    ev(1, 0, 0, 0);   chk("R4 single stop after ack", S_STOP, 4'b0101, 1, 0);
    write(1, 0, 0);   chk("R12 write while stopping", S_STOP, 4'b0000, 1, 0);
    ev(0, 0, 1, 0);   chk("R12 stop_sent to idle", S_IDLE, 4'b0000, 1, 0);
    @(negedge clk);   chk("R10 sd sticky", S_IDLE, 4'b0000, 1, 0);
    flags_clear();    chk("R10 clear", S_IDLE, 4'b0000, 0, 0);
    write(1, 0, 0);
    ev(0, 1, 0, 0);   chk("R13 single frame end", S_IDLE, 4'b0000, 1, 0);
    flags_clear();
  endtask

  task automatic t_refresh();
    loop_en = 1; trig_en = 0;
    write(1, 0, 0);
    ev(0, 1, 0, 0);   chk("R13 loop gap", S_GAP, 4'b0000, 0, 0);
    write(0, 0, 0);   chk("R9 null write in gap", S_GAP, 4'b0000, 0, 0);
    write(1, 0, 0);   chk("R3 begin in gap", S_GAP, 4'b0000, 0, 0);
    write(0, 0, 1);   chk("R5 refresh gap endseq abort", S_IDLE, 4'b0010, 1, 1);
    flags_clear();
    write(1, 0, 0); ev(0, 1, 0, 0);
    write(0, 1, 0);   chk("R5 refresh gap halt abort", S_IDLE, 4'b0010, 1, 1);
    flags_clear();
    write(1, 0, 0); ev(0, 1, 0, 0);
    ev(0, 0, 0, 1);   chk("R13 next_go restart", S_RUN, 4'b1000, 0, 0);
    write(0, 0, 0);   chk("R9 null write running", S_RUN, 4'b0000, 0, 0);
    write(0, 0, 1);
    ev(1, 0, 0, 0);   chk("R6 endseq ignores ack", S_RUN, 4'b0000, 0, 0);
    ev(0, 1, 0, 0);   chk("R6 stop at frame end", S_STOP, 4'b0100, 1, 1);
    ev(0, 0, 1, 0);   flags_clear();
    write(1, 0, 0);
    write(0, 1, 1);
    ev(1, 0, 0, 0);   chk("R11 halt outranks endseq", S_STOP, 4'b0101, 1, 1);
    ev(0, 0, 1, 0);   flags_clear();
    write(1, 0, 0);
    write(0, 0, 1);
    write(0, 1, 0);
    ev(1, 0, 0, 0);   chk("R12 halt ignored while pending", S_RUN, 4'b0000, 0, 0);
    ev(0, 1, 0, 0);   chk("R12 pending frame stop", S_STOP, 4'b0100, 1, 1);
    ev(0, 0, 1, 0);   flags_clear();
  endtask

  task automatic t_trigger();
    loop_en = 0; trig_en = 1;
    write(1, 0, 0);
    write(0, 0, 1);   chk("R8 trig run endseq abort", S_IDLE, 4'b0010, 1, 1);
    flags_clear();
    write(1, 0, 0);
    write(0, 1, 0);   chk("R8 trig run halt abort", S_IDLE, 4'b0010, 1, 1);
    flags_clear();
    write(1, 0, 0); ev(0, 1, 0, 0);
    write(0, 0, 1);   chk("R7 trig gap endseq held", S_GAP, 4'b0000, 0, 0);
    ev(0, 0, 0, 1);   chk("R7 trig restart", S_RUN, 4'b1000, 0, 0);
    ev(0, 1, 0, 0);   chk("R7 trig stop at frame end", S_STOP, 4'b0100, 1, 1);
    ev(0, 0, 1, 0);   flags_clear();
    write(1, 0, 0); ev(0, 1, 0, 0);
    write(0, 1, 0);   chk("R7 trig gap halt held", S_GAP, 4'b0000, 0, 0);
    ev(1, 0, 0, 0);   chk("R7 trig halt after ack", S_STOP, 4'b0101, 1, 1);
    ev(0, 0, 1, 0);
    @(negedge clk); clr = 1; write(1, 0, 0); clr = 0; // clear lands with no set
    write(0, 0, 1);   chk("R10 abort sets flags after clear", S_IDLE, 4'b0010, 1, 1);
    trig_en = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_refresh();
    t_trigger();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule